// File: doc/BRIEF.md
# Burst Read Port for a Byte-Addressed Memory

This block is the read half of a memory-mapped slave on an AXI-style bus. A master places a request on the read-address channel (start address, beat count minus one, transfer size, burst kind and a tag). The block takes one request at a time. It then returns the requested number of 32-bit beats on the read-data channel, each with a response code, and marks the final beat.

The memory itself sits outside the block. The block drives one byte address per data lane to a combinational read port and receives one byte per lane. For every beat it builds a little-endian word from consecutive byte locations. Bytes past the end of the memory come back as zero, and that beat is flagged with an error. Requests whose size exceeds the bus width, or whose burst kind is the reserved code, are answered with the full number of error beats. The block fetches no data for them.

Each beat passes through a check step, a presentation step that waits for the master's ready, and an advance step that moves to the next address. The next address is held constant, stepped linearly, or stepped inside an aligned wrap window.

Top module: `axi_rd_slave`

## Requirements
- R1: After reset is released, arready_o and rvalid_o are both low until a request is presented.
- R2: arready_o is high only while arvalid_i is high, and rid_o on every beat equals the arid_i captured with the request.
- R3: A request with length field L returns exactly L+1 beats, and rlast_o is high on the final beat only. After the handshake of that beat, rvalid_o is low in the following cycle.
- R4: While rvalid_o is high and rready_i is low, rvalid_o, rdata_o, rresp_o, rlast_o and rid_o hold their values.
- R5: Burst code 2'b00 (fixed): every beat uses the start address.
- R6: Burst code 2'b01 (incrementing): each beat address is the previous one plus 2^arsize bytes.
- R7: Burst code 2'b10 (wrapping): the window is (L+1)*2^arsize bytes, aligned to its own size. Addresses step by 2^arsize and fold back to the window base on reaching its top.
- R8: Lane k of rdata_o (bits 8k+7..8k) is the memory byte at beat address + k.
- R9: A beat whose four bytes all lie below the memory size returns rresp_o = 2'b00. Otherwise out-of-range lanes read 0 and rresp_o = 2'b10. No other response code appears.
- R10: A request with arsize_i greater than 2, or with burst code 2'b11, returns L+1 beats of zero data with rresp_o = 2'b10, and the address is not advanced.
- R11: arready_o stays low from the acceptance of a request until the handshake of its last beat, even while arvalid_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| arvalid_i | input | 1 | Read request valid |
| arready_o | output | 1 | Read request accepted |
| arid_i | input | ID_W | Request tag |
| araddr_i | input | ADDR_W | Start byte address |
| arlen_i | input | LEN_W | Beat count minus one |
| arsize_i | input | 3 | log2 of bytes per beat |
| arburst_i | input | 2 | Burst kind: 00 fixed, 01 incrementing, 10 wrapping, 11 reserved |
| rvalid_o | output | 1 | Read beat valid |
| rready_i | input | 1 | Master takes the beat |
| rid_o | output | ID_W | Tag of the current burst |
| rdata_o | output | 8*LANES | Beat data, little-endian |
| rresp_o | output | 2 | 00 okay, 10 slave error |
| rlast_o | output | 1 | Final beat of the burst |
| mem_addr_o | output | LANES*ADDR_W | Byte address per lane to the memory read port |
| mem_data_i | input | LANES*8 | Byte per lane from the memory read port |

## Verification
The bench sweeps every burst kind against sizes 0 to 2 and beat counts 1, 2, 4 and 8. It uses both a lane-aligned and an unaligned start address, so that fixed, linear and wrapped address sequences each give a different data pattern; the memory model returns a distinct arithmetic value per byte. Half of the sweep holds rready_i low for two cycles on every beat, which shows whether a stalled beat stays stable. A burst that runs off the end of the memory separates okay beats from partly zeroed error beats within one burst. Oversized transfers and the reserved burst code show that the error path still counts beats and does not fetch. Throughout each burst arvalid_i is held high with a different request, so an early acceptance would show up at arready_o.

// File: rtl/axi_rd_pkg.sv
package axi_rd_pkg;
  typedef enum logic [1:0] {
    BURST_FIXED = 2'b00,
    BURST_INCR  = 2'b01,
    BURST_WRAP  = 2'b10,
    BURST_RSVD  = 2'b11
  } burst_e;

  localparam logic [1:0] RESP_OKAY   = 2'b00;
  localparam logic [1:0] RESP_SLVERR = 2'b10;

  typedef enum logic [1:0] {AC_IDLE, AC_START, AC_READY} ac_state_e;

  typedef enum logic [2:0] {DC_IDLE, DC_CHECK, DC_WAIT, DC_XFER, DC_ERR} dc_state_e;
endpackage

// File: rtl/axi_rd_addr_ctrl.sv
module axi_rd_addr_ctrl
  import axi_rd_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ID_W   = 4,
  parameter int LEN_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              busy_i,
  input  logic              arvalid_i,
  input  logic [ID_W-1:0]   arid_i,
  input  logic [ADDR_W-1:0] araddr_i,
  input  logic [LEN_W-1:0]  arlen_i,
  input  logic [2:0]        arsize_i,
  input  logic [1:0]        arburst_i,
  output logic              arready_o,
  output logic              req_o,
  output logic [ID_W-1:0]   req_id_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [LEN_W-1:0]  req_len_o,
  output logic [2:0]        req_size_o,
  output logic [1:0]        req_burst_o
);
  ac_state_e st_q;

  assign arready_o = (st_q == AC_READY);
  assign req_o     = arready_o & arvalid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= AC_IDLE;
      req_id_o    <= '0;
      req_addr_o  <= '0;
      req_len_o   <= '0;
      req_size_o  <= '0;
      req_burst_o <= '0;
    end else begin
      unique case (st_q)
        AC_IDLE:  if (!busy_i) st_q <= AC_START;
        AC_START: if (arvalid_i) begin
          req_id_o    <= arid_i;
          req_addr_o  <= araddr_i;
          req_len_o   <= arlen_i;
          req_size_o  <= arsize_i;
          req_burst_o <= arburst_i;
          st_q        <= AC_READY;
        end
        AC_READY: if (arvalid_i) st_q <= AC_IDLE;
        default:  st_q <= AC_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/axi_rd_next_addr.sv
module axi_rd_next_addr
  import axi_rd_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int LEN_W    = 8,
  parameter int MAX_SIZE = 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [2:0]        size_i,
  input  logic [1:0]        burst_i,
  output logic [ADDR_W-1:0] next_o
);
  logic [ADDR_W-1:0] step, region, mask, lin;

  always_comb begin
    step   = ADDR_W'(1) << size_i;
    region = (ADDR_W'(len_i) + ADDR_W'(1)) << size_i;
    mask   = region - ADDR_W'(1);
    lin    = addr_i + step;
    next_o = addr_i;
    if (size_i <= 3'(MAX_SIZE)) begin
      unique case (burst_e'(burst_i))
        BURST_INCR: next_o = lin;
        BURST_WRAP: next_o = (addr_i & ~mask) | (lin & mask);
        default:    next_o = addr_i;
      endcase
    end
  end
endmodule

// File: rtl/axi_rd_beat_fetch.sv
module axi_rd_beat_fetch #(
  parameter int ADDR_W    = 32,
  parameter int LANES     = 4,
  parameter int MEM_BYTES = 512
) (
  input  logic [ADDR_W-1:0]       beat_addr_i,
  input  logic                    reject_i,
  output logic [LANES*ADDR_W-1:0] mem_addr_o,
  input  logic [LANES*8-1:0]      mem_data_i,
  output logic [LANES*8-1:0]      data_o,
  output logic                    err_o
);
  localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(MEM_BYTES);
  logic [LANES-1:0] in_range;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [ADDR_W:0] sum;
    assign sum = {1'b0, beat_addr_i} + (ADDR_W+1)'(k);
    assign mem_addr_o[k*ADDR_W +: ADDR_W] = sum[ADDR_W-1:0];
    assign in_range[k] = (sum < LIMIT);
    assign data_o[k*8 +: 8] = (in_range[k] && !reject_i) ? mem_data_i[k*8 +: 8] : 8'h00;
  end

  assign err_o = reject_i | ~(&in_range);
endmodule

// File: rtl/axi_rd_slave.sv
module axi_rd_slave
  import axi_rd_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int ID_W      = 4,
  parameter int LEN_W     = 8,
  parameter int LANES     = 4,
  parameter int MEM_BYTES = 512
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    arvalid_i,
  output logic                    arready_o,
  input  logic [ID_W-1:0]         arid_i,
  input  logic [ADDR_W-1:0]       araddr_i,
  input  logic [LEN_W-1:0]        arlen_i,
  input  logic [2:0]              arsize_i,
  input  logic [1:0]              arburst_i,
  output logic                    rvalid_o,
  input  logic                    rready_i,
  output logic [ID_W-1:0]         rid_o,
  output logic [LANES*8-1:0]      rdata_o,
  output logic [1:0]              rresp_o,
  output logic                    rlast_o,
  output logic [LANES*ADDR_W-1:0] mem_addr_o,
  input  logic [LANES*8-1:0]      mem_data_i
);
  localparam int DATA_W   = LANES * 8;
  localparam int MAX_SIZE = $clog2(LANES);

  dc_state_e         st_q;
  logic              busy, req, reject, fetch_err;
  logic [ID_W-1:0]   req_id, id_q;
  logic [ADDR_W-1:0] req_addr, addr_q, addr_nxt;
  logic [LEN_W-1:0]  req_len, len_q, cnt_q;
  logic [2:0]        req_size, size_q;
  logic [1:0]        req_burst, burst_q;
  logic [DATA_W-1:0] fetch_data, rdata_q;
  logic [1:0]        rresp_q;
  logic              rlast_q;

  assign busy   = (st_q != DC_IDLE);
  assign reject = (size_q > 3'(MAX_SIZE)) || (burst_q == BURST_RSVD);

  axi_rd_addr_ctrl #(.ADDR_W(ADDR_W), .ID_W(ID_W), .LEN_W(LEN_W)) u_ac (
    .clk_i, .rst_ni, .busy_i(busy), .arvalid_i, .arid_i, .araddr_i,
    .arlen_i, .arsize_i, .arburst_i, .arready_o, .req_o(req),
    .req_id_o(req_id), .req_addr_o(req_addr), .req_len_o(req_len),
    .req_size_o(req_size), .req_burst_o(req_burst)
  );

  axi_rd_next_addr #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .MAX_SIZE(MAX_SIZE)) u_na (
    .addr_i(addr_q), .len_i(len_q), .size_i(size_q), .burst_i(burst_q), .next_o(addr_nxt)
  );

  axi_rd_beat_fetch #(.ADDR_W(ADDR_W), .LANES(LANES), .MEM_BYTES(MEM_BYTES)) u_bf (
    .beat_addr_i(addr_q), .reject_i(reject), .mem_addr_o, .mem_data_i,
    .data_o(fetch_data), .err_o(fetch_err)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= DC_IDLE;
      id_q    <= '0;
      addr_q  <= '0;
      len_q   <= '0;
      size_q  <= '0;
      burst_q <= '0;
      cnt_q   <= '0;
      rdata_q <= '0;
      rresp_q <= RESP_OKAY;
      rlast_q <= 1'b0;
    end else begin
      unique case (st_q)
        DC_IDLE: if (req) begin
          id_q    <= req_id;
          addr_q  <= req_addr;
          len_q   <= req_len;
          size_q  <= req_size;
          burst_q <= req_burst;
          cnt_q   <= '0;
          st_q    <= DC_CHECK;
        end
        DC_CHECK: begin
          rdata_q <= fetch_data;
          rresp_q <= fetch_err ? RESP_SLVERR : RESP_OKAY;
          rlast_q <= (cnt_q == len_q);
          st_q    <= fetch_err ? DC_ERR : DC_WAIT;
        end
        DC_WAIT, DC_ERR: if (rready_i) st_q <= rlast_q ? DC_IDLE : DC_XFER;
        DC_XFER: begin
          addr_q <= addr_nxt;
          cnt_q  <= cnt_q + LEN_W'(1);
          st_q   <= DC_CHECK;
        end
        default: st_q <= DC_IDLE;
      endcase
    end
  end

  assign rvalid_o = (st_q == DC_WAIT) || (st_q == DC_ERR);
  assign rid_o    = id_q;
  assign rdata_o  = rdata_q;
  assign rresp_o  = rresp_q;
  assign rlast_o  = rlast_q;
endmodule

// File: rtl/axi_rd_slave_chk.sv
module axi_rd_slave_chk #(
  parameter int ID_W  = 4,
  parameter int LANES = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               arvalid_i,
  input logic               arready_o,
  input logic               rvalid_o,
  input logic               rready_i,
  input logic [ID_W-1:0]    rid_o,
  input logic [LANES*8-1:0] rdata_o,
  input logic [1:0]         rresp_o,
  input logic               rlast_o
);
  assert_arready_with_valid_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arready_o |-> arvalid_i);

  assert_stall_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o && !rready_i |=> rvalid_o && $stable(rdata_o) && $stable(rresp_o)
                              && $stable(rlast_o) && $stable(rid_o));

  assert_last_closes_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o && rready_i && rlast_o |=> !rvalid_o);

  assert_resp_codes_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> (rresp_o == 2'b00 || rresp_o == 2'b10));

  assert_no_accept_mid_burst_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> !arready_o);
endmodule

bind axi_rd_slave axi_rd_slave_chk #(.ID_W(ID_W), .LANES(LANES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .arvalid_i(arvalid_i), .arready_o(arready_o),
  .rvalid_o(rvalid_o), .rready_i(rready_i), .rid_o(rid_o), .rdata_o(rdata_o),
  .rresp_o(rresp_o), .rlast_o(rlast_o)
);

// File: tb/axi_rd_slave_tb.sv
module axi_rd_slave_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32, ID_W = 4, LEN_W = 8, LANES = 4, MEM_BYTES = 512;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic arvalid = 1'b0, rready = 1'b0;
  logic arready, rvalid, rlast;
  logic [ID_W-1:0] arid = '0, rid;
  logic [ADDR_W-1:0] araddr = '0;
  logic [LEN_W-1:0] arlen = '0;
  logic [2:0] arsize = '0;
  logic [1:0] arburst = '0, rresp;
  logic [31:0] rdata;
  logic [LANES*ADDR_W-1:0] mem_addr;
  logic [LANES*8-1:0] mem_data;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] mem_byte(input logic [ADDR_W-1:0] a);
    return 8'(a * 29 + (a >> 5) + 11);
  endfunction

  always_comb
    for (int k = 0; k < LANES; k++) mem_data[k*8 +: 8] = mem_byte(mem_addr[k*ADDR_W +: ADDR_W]);

  axi_rd_slave u_dut (
    .clk_i(clk), .rst_ni, .arvalid_i(arvalid), .arready_o(arready), .arid_i(arid),
    .araddr_i(araddr), .arlen_i(arlen), .arsize_i(arsize), .arburst_i(arburst),
    .rvalid_o(rvalid), .rready_i(rready), .rid_o(rid), .rdata_o(rdata), .rresp_o(rresp),
    .rlast_o(rlast), .mem_addr_o(mem_addr), .mem_data_i(mem_data)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit bad_req(input logic [2:0] s, input logic [1:0] b);
    return (s > 3'd2) || (b == 2'b11);
  endfunction

  function automatic logic [31:0] exp_next(input logic [31:0] a, input int len,
                                           input logic [2:0] s, input logic [1:0] b);
    int step, region, base;
    if (bad_req(s, b) || b == 2'b00) return a;    // R5 R10
    step = 1 << s;
    if (b == 2'b01) return a + 32'(step);          // R6
    region = (len + 1) * step;                     // R7
    base = (int'(a) / region) * region;
    return 32'(base + ((int'(a) + step - base) % region));
  endfunction

  task automatic do_read(input logic [31:0] a, input int len, input logic [2:0] s,
                         input logic [1:0] b, input logic [3:0] id, input bit stall);
    logic [31:0] ea = a;
    @(negedge clk);
    arvalid = 1'b1; araddr = a; arlen = LEN_W'(len); arsize = s; arburst = b; arid = id;
    do @(negedge clk); while (!arready);
    @(negedge clk);
    araddr = 32'h1F0; arid = ~id;                  // R11: competing request held during burst
    for (int bt = 0; bt <= len; bt++) begin
      logic [31:0] ed = '0;
      bit err = bad_req(s, b);
      while (!rvalid) begin
        check(arready == 1'b0, "R11 arready during burst", arready, 0);
        @(negedge clk);
      end
      for (int k = 0; k < 4; k++) begin
        if (ea + 32'(k) < MEM_BYTES) begin
          if (!bad_req(s, b)) ed[k*8 +: 8] = mem_byte(ea + 32'(k));
        end else err = 1'b1;
      end
      if (stall) begin
        logic [31:0] d0 = rdata;
        logic [1:0] r0 = rresp;
        logic l0 = rlast;
        repeat (2) @(negedge clk);
        check(rvalid && rdata == d0 && rresp == r0 && rlast == l0, "R4 stalled beat",
              {rvalid, rdata}, {1'b1, d0});
      end
      check(rdata == ed, $sformatf("R8 R5 R6 R7 data b=%0d s=%0d len=%0d beat=%0d", b, s, len, bt),
            rdata, ed);
      check(rresp == (err ? 2'b10 : 2'b00), $sformatf("R9 R10 resp addr=%0h", ea), rresp,
            err ? 2'b10 : 2'b00);
      check(rlast == (bt == len), "R3 rlast", rlast, bt == len);
      check(rid == id, "R2 rid", rid, id);
      rready = 1'b1;
      @(negedge clk);
      rready = 1'b0;
      if (bt == len) begin
        arvalid = 1'b0;
        check(!rvalid, "R3 no beat after last", rvalid, 0);
      end
      ea = exp_next(ea, len, s, b);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int lens[4] = '{0, 1, 3, 7};
    logic [31:0] starts[2] = '{32'd36, 32'd203};
    bit stall = 1'b0;
    repeat (3) @(negedge clk);
    check(!arready && !rvalid, "R1 reset outputs", {arready, rvalid}, 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    check(!arready && !rvalid, "R1 idle after reset", {arready, rvalid}, 0);
    for (int b = 0; b < 3; b++)
      for (int s = 0; s < 3; s++)
        for (int li = 0; li < 4; li++)
          for (int ai = 0; ai < 2; ai++) begin
            do_read(starts[ai], lens[li], 3'(s), 2'(b), 4'(b*5 + s + li), stall);
            stall = ~stall;
          end
    do_read(32'd504, 3, 3'd2, 2'b01, 4'hA, 1'b0);  // R9 runs past end
    do_read(32'd510, 1, 3'd0, 2'b00, 4'hB, 1'b1);  // R9 partial lanes
    do_read(32'd16, 2, 3'd3, 2'b01, 4'hC, 1'b0);   // R10 oversize
    do_read(32'd20, 1, 3'd1, 2'b11, 4'hD, 1'b1);   // R10 reserved burst
    do_read(32'd64, 3, 3'd2, 2'b10, 4'hE, 1'b0);   // R7 aligned wrap after errors
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule